// File: doc/BRIEF.md
# SDR/DDR Serial Shift Engine

This block moves the bits of one transfer phase (command, address, alternate bytes or data) between a parallel word and up to four serial lanes. It generates its own serial clock from the system clock. Every serial clock edge is also a system clock edge, so each launch or sample point appears inside the design as a one-cycle strobe. A controller sets the phase kind, the lane count, the rate mode, the sample-shift option, the bit count and the clock divider, presents the transmit word and pulses `start`. The engine then shifts the word out most significant bit first, assembles the sampled lane bits into receive bytes and pulses `done` once the serial clock has returned low.

In single data rate, one lane group is launched on each falling serial clock edge. A receive group is sampled on the rising edge that follows the launch, or one half-period later when the sample-shift option is set. In double data rate, the address, alternate and data phases launch a lane group on every edge, and each group is sampled on the next, opposite edge. A command phase ignores the double-rate request and always runs at single rate. A start that asks for double rate together with sample shift, or that has an inconsistent length, lane or divider setting, is refused with an error pulse.

Top module: `ser_shift_engine`

## Requirements
- R1: After reset, and whenever no transfer is running, `sck` is 0 and `ioOut`, `busy`, `done`, `rxValid` and `cfgErr` are 0.
- R2: A transfer is accepted on the `start` cycle. Each serial clock half-period lasts `halfPeriod` system cycles, so `done` rises exactly `edges * halfPeriod` cycles after `busy` rises, where `edges` is the count given in R11.
- R3: `laneSel` 0, 1 and 2 select 1, 2 and 4 lanes. Groups are taken from `txWord` most significant bits first. Within a group, the highest used lane (`ioOut[n-1]`) carries the most significant bit. Unused lanes stay 0.
- R4: In single rate, `ioOut` shows the first group in the cycle after `start` is accepted and changes afterwards only on falling `sck` edges.
- R5: In single rate with `sampleShift` = 0, `ioIn` is sampled on the rising edge after each launch. With `sampleShift` = 1, it is sampled on the falling edge after that.
- R6: With `ddrEn` = 1 and `phaseSel` not 0, a new group is launched on every `sck` edge, and each group is sampled on the next, opposite edge.
- R7: A command phase (`phaseSel` = 0) runs with single-rate timing whatever the value of `ddrEn`.
- R8: Sampled groups are packed most significant first, with `ioIn[n-1]` as the most significant bit of each group. Every complete 8 bits gives a one-cycle `rxValid` pulse with the byte on `rxByte`. A partial byte at the end of a transfer is discarded.
- R9: A `start` with both `ddrEn` and `sampleShift` at 1 is refused: `cfgErr` pulses for one cycle and no transfer begins. This applies to command phases too.
- R10: A `start` is also refused with a `cfgErr` pulse when `numBits` is 0 or larger than the word, when it is not a multiple of the lane count, when `laneSel` is 3, or when `halfPeriod` is 0.
- R11: A transfer of u groups uses 2u edges in single rate and u rounded up to even in double rate. At the last edge, `sck` returns to 0, `busy` falls and `done` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one phase (ignored while busy) |
| phaseSel | input | 2 | 0 command, 1 address, 2 alternate, 3 data |
| laneSel | input | 2 | 0 one lane, 1 two lanes, 2 four lanes |
| ddrEn | input | 1 | Request double data rate |
| sampleShift | input | 1 | Delay single-rate sampling by half a serial clock |
| numBits | input | LEN_W | Bits in this phase |
| halfPeriod | input | DIV_W | System cycles per serial clock half-period |
| txWord | input | WORD_W | Transmit bits, left aligned |
| ioIn | input | 4 | Lane input values |
| sck | output | 1 | Serial clock, idle low |
| ioOut | output | 4 | Lane output values |
| rxByte | output | 8 | Last assembled receive byte |
| rxValid | output | 1 | One-cycle strobe for `rxByte` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-phase pulse |
| cfgErr | output | 1 | One-cycle pulse for a refused start |

## Verification
The assertions check on every cycle that the serial clock idles low, that `done` is a single pulse with the clock low, that refused starts never run and that no transfer runs with double rate and sample shift together. They also check the launch rule: single-rate outputs move only on falling edges, and double-rate outputs move only on clock edges. Only the bench scenarios can show that the group values and their order are right, which edge actually captures the input (rising, shifted or opposite), that command phases drop double rate, that odd group counts add a trailing edge and that the cycle counts follow the divider.

// File: rtl/sse_pkg.sv
package sse_pkg;

  localparam int LANE_MAX = 4;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_ALT  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_BAD = 2'd3
  } laneMode_t;

  // Control -> datapath strobes, one system cycle wide
  typedef struct packed {
    logic       load;     // capture txWord, clear receive assembly
    logic       launch;   // advance to next transmit group
    logic       sample;   // capture ioIn group
    logic       active;   // transfer running
    logic       ddrMode;  // effective double rate for this phase
    logic [1:0] laneCode; // latched lane selection
  } strobe_t;

  function automatic logic [2:0] laneWidth(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sse_ctrl.sv
module sse_ctrl
  import sse_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       phaseSel,
  input  logic [1:0]       laneSel,
  input  logic             ddrEn,
  input  logic             sampleShift,
  input  logic [LEN_W-1:0] numBits,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             sck,
  output logic             busy,
  output logic             done,
  output logic             cfgErr,
  output strobe_t          strb
);

  localparam int EDGE_W = $clog2(2 * WORD_W + 1);

  logic [DIV_W-1:0]  halfCnt, halfLat;
  logic [EDGE_W-1:0] edgeNum, nextEdge, lastEdgeLat, lastEdgeReq;
  logic [LEN_W-1:0]  unitsLat, unitsReq;
  logic              ddrLat, ddrRawLat, ssLat;
  logic [1:0]        laneLat;
  logic              sckQ, busyQ, doneQ, errQ;
  logic              misaligned, ddrSsConflict, badCfg, ddrEffReq, tick;

  // ---------------- start-time configuration check ----------------
  always_comb begin
    case (laneSel)
      2'd1:    misaligned = numBits[0];
      2'd2:    misaligned = |numBits[1:0];
      default: misaligned = 1'b0;
    endcase
    ddrSsConflict = ddrEn && sampleShift;
    badCfg = ddrSsConflict
          || (numBits == '0)
          || (numBits > LEN_W'(WORD_W))
          || (laneMode_t'(laneSel) == LANE_BAD)
          || (halfPeriod == '0)
          || misaligned;
    // command phase never runs at double rate
    ddrEffReq = ddrEn && (phase_t'(phaseSel) != PH_CMD);
    unitsReq  = numBits >> laneSel;
    // SDR: two edges per group; DDR: one edge per group, padded so sck ends low
    lastEdgeReq = ddrEffReq ? (EDGE_W'(unitsReq) + EDGE_W'(unitsReq[0]))
                            : (EDGE_W'(unitsReq) << 1);
  end

  // ---------------- serial clock timing ----------------
  assign tick     = busyQ && (halfCnt == halfLat - 1'b1);
  assign nextEdge = edgeNum + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt     <= '0;
      halfLat     <= '0;
      edgeNum     <= '0;
      lastEdgeLat <= '0;
      unitsLat    <= '0;
      ddrLat      <= 1'b0;
      ddrRawLat   <= 1'b0;
      ssLat       <= 1'b0;
      laneLat     <= 2'd0;
      sckQ        <= 1'b0;
      busyQ       <= 1'b0;
      doneQ       <= 1'b0;
      errQ        <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          if (badCfg) begin
            errQ <= 1'b1;
          end else begin
            busyQ       <= 1'b1;
            halfCnt     <= '0;
            edgeNum     <= '0;
            halfLat     <= halfPeriod;
            lastEdgeLat <= lastEdgeReq;
            unitsLat    <= unitsReq;
            ddrLat      <= ddrEffReq;
            ddrRawLat   <= ddrEn;
            ssLat       <= sampleShift;
            laneLat     <= laneSel;
          end
        end
      end else if (tick) begin
        halfCnt <= '0;
        edgeNum <= nextEdge;
        sckQ    <= ~sckQ;
        if (nextEdge == lastEdgeLat) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // ---------------- strobes to the datapath ----------------
  // Edge n (n >= 1) is rising when odd, falling when even; edge 0 is the start.
  always_comb begin
    strb          = '0;
    strb.active   = busyQ;
    strb.ddrMode  = ddrLat;
    strb.laneCode = laneLat;
    strb.load     = !busyQ && start && !badCfg;
    if (tick) begin
      if (ddrLat) begin
        strb.launch = nextEdge < EDGE_W'(unitsLat);
        strb.sample = nextEdge <= EDGE_W'(unitsLat);
      end else begin
        strb.launch = !nextEdge[0] && (nextEdge != lastEdgeLat);
        strb.sample = ssLat ? !nextEdge[0] : nextEdge[0];
      end
    end
  end

  assign sck    = sckQ;
  assign busy   = busyQ;
  assign done   = doneQ;
  assign cfgErr = errQ;

  // ---------------- assertions ----------------
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !sckQ) else $error("serial clock high while idle"); // R1

  AST_DONE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!sckQ && !busyQ)) else $error("done without idle low clock"); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ) else $error("done longer than one cycle"); // R11

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (edgeNum < lastEdgeLat)) else $error("edge count overrun"); // R11

  AST_REFUSED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !busyQ) else $error("refused start began a transfer"); // R9

  AST_NO_SHIFT_IN_DDR: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !(ddrRawLat && ssLat)) else $error("sample shift with double rate"); // R9

endmodule

// File: rtl/sse_datapath.sv
module sse_datapath
  import sse_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [WORD_W-1:0]   txWord,
  input  logic [LANE_MAX-1:0] ioIn,
  output logic [LANE_MAX-1:0] ioOut,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                rxValid
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [WORD_W-1:0]   shReg;
  logic [BYTE_W-1:0]   rxSh, rxNext;
  logic [CNT_W-1:0]    rxCnt, rxCntNext;
  logic [2:0]          width;
  logic [LANE_MAX-1:0] laneMask, topBits;

  always_comb begin
    width     = laneWidth(strb.laneCode);
    laneMask  = LANE_MAX'((1 << width) - 1);
    // top group of the word, right aligned to lane 0
    topBits   = shReg[WORD_W-1 -: LANE_MAX];
    ioOut     = strb.active ? (topBits >> (3'(LANE_MAX) - width)) : '0;
    rxNext    = (rxSh << width) | BYTE_W'(ioIn & laneMask);
    rxCntNext = rxCnt + CNT_W'(width);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      rxSh    <= '0;
      rxCnt   <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.load) begin
        shReg <= txWord;
        rxSh  <= '0;
        rxCnt <= '0;
      end else begin
        if (strb.launch) begin
          shReg <= shReg << width;
        end
        if (strb.sample) begin
          if (rxCntNext == CNT_W'(BYTE_W)) begin
            rxByte  <= rxNext;
            rxValid <= 1'b1;
            rxSh    <= '0;
            rxCnt   <= '0;
          end else begin
            rxSh  <= rxNext;
            rxCnt <= rxCntNext;
          end
        end
      end
    end
  end

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid) else $error("receive strobe held"); // R8

  AST_RX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt < CNT_W'(BYTE_W)) else $error("receive count out of range"); // R8

endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
  import sse_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        phaseSel,
  input  logic [1:0]        laneSel,
  input  logic              ddrEn,
  input  logic              sampleShift,
  input  logic [LEN_W-1:0]  numBits,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic [WORD_W-1:0] txWord,
  input  logic [3:0]        ioIn,
  output logic              sck,
  output logic [3:0]        ioOut,
  output logic [7:0]        rxByte,
  output logic              rxValid,
  output logic              busy,
  output logic              done,
  output logic              cfgErr
);

  strobe_t strb;

  sse_ctrl #(
    .WORD_W (WORD_W),
    .DIV_W  (DIV_W),
    .LEN_W  (LEN_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .phaseSel    (phaseSel),
    .laneSel     (laneSel),
    .ddrEn       (ddrEn),
    .sampleShift (sampleShift),
    .numBits     (numBits),
    .halfPeriod  (halfPeriod),
    .sck         (sck),
    .busy        (busy),
    .done        (done),
    .cfgErr      (cfgErr),
    .strb        (strb)
  );

  sse_datapath #(
    .WORD_W (WORD_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txWord  (txWord),
    .ioIn    (ioIn),
    .ioOut   (ioOut),
    .rxByte  (rxByte),
    .rxValid (rxValid)
  );

  // Launch-edge rules, spanning control (sck) and datapath (ioOut)
  AST_SDR_FALLING_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !strb.ddrMode && (ioOut != $past(ioOut))) |-> $fell(sck))
    else $error("single-rate output moved off a falling edge"); // R4

  AST_DDR_EDGE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (ioOut != $past(ioOut))) |-> (sck != $past(sck)))
    else $error("output moved between clock edges"); // R6

endmodule

// File: tb/ser_shift_engine_test.sv
module ser_shift_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int DIV_W      = 8;
  localparam int LEN_W      = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        phaseSel = 2'd0;
  logic [1:0]        laneSel = 2'd0;
  logic              ddrEn = 1'b0;
  logic              sampleShift = 1'b0;
  logic [LEN_W-1:0]  numBits = '0;
  logic [DIV_W-1:0]  halfPeriod = 8'd1;
  logic [WORD_W-1:0] txWord = '0;
  logic [3:0]        ioIn = 4'd0;
  logic              sck, rxValid, busy, done, cfgErr;
  logic [3:0]        ioOut;
  logic [7:0]        rxByte;

  ser_shift_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .phaseSel(phaseSel), .laneSel(laneSel),
    .ddrEn(ddrEn), .sampleShift(sampleShift), .numBits(numBits),
    .halfPeriod(halfPeriod), .txWord(txWord), .ioIn(ioIn), .sck(sck),
    .ioOut(ioOut), .rxByte(rxByte), .rxValid(rxValid), .busy(busy),
    .done(done), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // ---------------- scoreboard state ----------------
  int         txEdgeQ[$];
  logic [3:0] txValQ[$];
  logic [7:0] rxQ[$];
  bit         phaseOpen = 1'b0;
  int         expEdges, expCycles, edgeCnt, startCyc, seed;
  logic [3:0] curExp = 4'd0;
  string      tag;
  logic       prevSck = 1'b0;
  logic       prevBusy = 1'b0;

  // value the simulated device puts on the lanes after edge n
  function automatic logic [3:0] pat(input int n, input int s);
    return 4'((n * 11 + s) ^ (n >> 2));
  endfunction

  task automatic onEdge();
    ioIn = pat(edgeCnt, seed);
    if (txEdgeQ.size() > 0 && txEdgeQ[0] == edgeCnt) begin
      void'(txEdgeQ.pop_front());
      curExp = txValQ.pop_front();
      check(ioOut == curExp, $sformatf("%s launch at edge %0d: ioOut got %h exp %h",
                                       tag, edgeCnt, ioOut, curExp));
    end else begin
      check(ioOut == curExp, $sformatf("%s hold at edge %0d: ioOut got %h exp %h",
                                       tag, edgeCnt, ioOut, curExp));
    end
  endtask

  // ---------------- monitor ----------------
  always @(posedge clk) begin
    #2;
    if (phaseOpen) begin
      if (busy && !prevBusy) begin
        edgeCnt  = 0;
        startCyc = cyc;
        onEdge();
      end else if (sck != prevSck) begin
        edgeCnt++;
        if (busy) onEdge();
      end
      if (rxValid) begin
        if (rxQ.size() == 0) begin
          check(1'b0, $sformatf("%s R8 unexpected byte: got %h exp none", tag, rxByte));
        end else begin
          logic [7:0] e;
          e = rxQ.pop_front();
          check(rxByte == e, $sformatf("%s R8 rx byte: got %h exp %h", tag, rxByte, e));
        end
      end
      if (done) begin
        check(edgeCnt == expEdges, $sformatf("%s R11 edge count: got %0d exp %0d",
                                             tag, edgeCnt, expEdges));
        check(cyc - startCyc == expCycles, $sformatf("%s R2 duration: got %0d exp %0d",
                                                     tag, cyc - startCyc, expCycles));
        check(!sck && !busy, $sformatf("%s R11 end state sck/busy: got %b%b exp 00",
                                       tag, sck, busy));
        phaseOpen = 1'b0;
      end
    end
    prevSck  = sck;
    prevBusy = busy;
  end

  // ---------------- driver ----------------
  task automatic runPhase(input string t, input logic [1:0] ph, input logic [1:0] ln,
                          input bit ddr, input bit ss, input int nb,
                          input logic [31:0] w, input int h, input int sd);
    int  lw, units, acc, bits;
    bit  dEff;
    lw    = 1 << ln;
    units = nb / lw;
    dEff  = ddr && (ph != 2'd0);
    acc   = 0;
    bits  = 0;
    tag   = t;
    seed  = sd;
    curExp = 4'd0;
    for (int k = 0; k < units; k++) begin
      logic [31:0] sh;
      int p;
      sh = w << (k * lw);
      txEdgeQ.push_back(dEff ? k : 2 * k);
      txValQ.push_back(4'(sh >> (32 - lw)));
      p = dEff ? k : (ss ? 2 * k + 1 : 2 * k);
      acc = (acc << lw) | int'(pat(p, sd) & 4'((1 << lw) - 1));
      bits += lw;
      if (bits == 8) begin
        rxQ.push_back(8'(acc));
        acc  = 0;
        bits = 0;
      end
    end
    expEdges  = dEff ? units + (units % 2) : 2 * units;
    expCycles = expEdges * h;
    @(negedge clk);
    phaseSel    = ph;
    laneSel     = ln;
    ddrEn       = ddr;
    sampleShift = ss;
    numBits     = LEN_W'(nb);
    halfPeriod  = DIV_W'(h);
    txWord      = w;
    phaseOpen   = 1'b1;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (!phaseOpen);
    check(txEdgeQ.size() == 0, $sformatf("%s R3 launches missing: got %0d left exp 0",
                                         tag, txEdgeQ.size()));
    check(rxQ.size() == 0, $sformatf("%s R8 bytes missing: got %0d left exp 0",
                                     tag, rxQ.size()));
    txEdgeQ.delete();
    txValQ.delete();
    rxQ.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic tryBad(input string t, input logic [1:0] ph, input logic [1:0] ln,
                        input bit ddr, input bit ss, input int nb, input int h);
    @(negedge clk);
    phaseSel    = ph;
    laneSel     = ln;
    ddrEn       = ddr;
    sampleShift = ss;
    numBits     = LEN_W'(nb);
    halfPeriod  = DIV_W'(h);
    start       = 1'b1;
    @(posedge clk);
    #2;
    check(cfgErr && !busy, $sformatf("%s refuse: cfgErr/busy got %b%b exp 10", t, cfgErr, busy));
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    #2;
    check(!cfgErr && !busy && !sck && ioOut == 4'd0,
          $sformatf("%s after refuse: cfgErr/busy/sck/ioOut got %b%b%b %h exp 000 0",
                    t, cfgErr, busy, sck, ioOut));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired: got hang exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check(!sck && ioOut == 4'd0 && !busy && !done && !rxValid && !cfgErr,
          $sformatf("R1 reset state: sck/busy/done/rxValid/cfgErr/ioOut got %b%b%b%b%b %h exp 00000 0",
                    sck, busy, done, rxValid, cfgErr, ioOut));

    runPhase("R4 R5 sdr x1 rise-sample", 2'd1, 2'd0, 1'b0, 1'b0, 8, 32'hA5C3_0000, 2, 3);
    runPhase("R5 sdr x1 shifted-sample", 2'd3, 2'd0, 1'b0, 1'b1, 16, 32'h3C96_0000, 3, 7);
    runPhase("R3 sdr x4", 2'd3, 2'd2, 1'b0, 1'b0, 32, 32'h1234_ABCD, 1, 5);
    runPhase("R3 sdr x2 shifted", 2'd2, 2'd1, 1'b0, 1'b1, 16, 32'hE1B4_0000, 1, 9);
    runPhase("R6 ddr x4", 2'd1, 2'd2, 1'b1, 1'b0, 24, 32'h9F3A_5100, 2, 2);
    runPhase("R6 R11 ddr x2 odd groups", 2'd3, 2'd1, 1'b1, 1'b0, 10, 32'hB7C0_0000, 3, 11);
    runPhase("R7 command ignores ddr", 2'd0, 2'd0, 1'b1, 1'b0, 8, 32'h6B00_0000, 1, 4);
    runPhase("R2 R8 ddr x1 partial byte", 2'd2, 2'd0, 1'b1, 1'b0, 12, 32'hD5E0_0000, 4, 6);

    tryBad("R9 ddr with shift", 2'd3, 2'd0, 1'b1, 1'b1, 8, 2);
    tryBad("R9 ddr with shift on command", 2'd0, 2'd0, 1'b1, 1'b1, 8, 2);
    tryBad("R10 zero bits", 2'd1, 2'd0, 1'b0, 1'b0, 0, 2);
    tryBad("R10 bits over word", 2'd1, 2'd0, 1'b0, 1'b0, 33, 2);
    tryBad("R10 misaligned x4", 2'd3, 2'd2, 1'b0, 1'b0, 6, 2);
    tryBad("R10 lane code 3", 2'd3, 2'd3, 1'b0, 1'b0, 8, 2);
    tryBad("R10 zero divider", 2'd3, 2'd0, 1'b0, 1'b0, 8, 0);

    runPhase("R1 R4 sdr after refusals", 2'd1, 2'd1, 1'b0, 1'b0, 8, 32'h5A00_0000, 2, 8);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule